// File: doc/BRIEF.md
# Multi-Channel DAC Gain and Offset Trim

This block keeps a bank of per-channel calibration registers and turns each channel's raw sample into a trimmed 12-bit code for a resistor-string converter. A single parallel write port carries a channel number, a two-bit register select and a 12-bit word. The word lands in one of three registers of the addressed channel: the raw sample, the offset trim or the gain trim.

Every channel continuously forms its trimmed code from those three registers. The trim registers act as the first buffer stage. A load strobe copies the trimmed codes of all channels into the output registers on one clock edge. The outputs therefore never show a half-finished update across channels.

The trim is `out = ((gain + 2) * sample) / 4096 + offset - 2048`. The product is kept at full width and the division truncates. The sum is clamped to the code range. After reset the trims give unity gain and zero shift, so the output equals the sample.

Top module: `dac_trim_array`

## Requirements
- R1: A write takes effect on the clock edge where `wr_en` is high. The select values are 2'b11 for the sample register, 2'b10 for the offset register and 2'b01 for the gain register.
- R2: Each channel's trimmed code is ((gain + 2) * sample) / 4096 + offset - 2048. The product is at full precision and the division truncates toward zero.
- R3: A trimmed result below 0 is output as 0, and a result above 4095 is output as 4095.
- R4: Reset (synchronous, active low) sets every gain to 0xFFE, every offset to 0x800, every sample to 0 and every output code to 0. With these trims a channel outputs its sample unchanged.
- R5: Gain is written from `wr_data[11:1]`, and bit 0 of the stored gain is always 0. For example, writing 0x001 stores a gain of 0x000.
- R6: The offset is offset-binary. 0x800 adds nothing, each code step above or below it adds or removes one LSB, and 0x000 subtracts 2048. Gain 0x7FE halves the sample and 0xBFE scales it by 0.75.
- R7: Output codes change only on an edge where `load` is high. All channels update on that same edge.
- R8: A load captures every write made in an earlier cycle. A write in the same cycle as the load is not seen until the next load.
- R9: A write to a channel number of `NUM_CH` (40) or above changes no register.
- R10: A write with select 2'b00 is accepted and changes no register.
- R11: Each channel has its own three registers. A write to one channel leaves every other channel's output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 6 | Channel number of the write |
| wr_sel | input | 2 | Register select (11 sample, 10 offset, 01 gain, 00 none) |
| wr_data | input | 12 | Write data word |
| load | input | 1 | Copies all trimmed codes to the outputs |
| dac_code | output | 480 | Output codes, channel k at bits [12k+11:12k] |

## Verification
The assertions assume that `wr_en`, `wr_addr`, `wr_sel`, `wr_data` and `load` carry known values on every clock edge after reset. They also assume that a load may arrive in the same cycle as a write. The stimulus meets both assumptions: it drives every input from reset onward, changes inputs only on falling edges, and returns `wr_en` and `load` to 0 between operations. The stimulus also exercises the same-cycle case on purpose. Out-of-range channel numbers and the unused select value are applied as ordinary writes, so the bench can observe at the outputs that they have no effect.

// File: rtl/dac_trim_pkg.sv
// Shared definitions for the DAC trim array.
// Assumes a two-bit register select on the write port.
package dac_trim_pkg;

    // Register select values seen on wr_sel.
    typedef enum logic [1:0] {
        SEL_NONE   = 2'b00,
        SEL_GAIN   = 2'b01,
        SEL_OFFSET = 2'b10,
        SEL_SAMPLE = 2'b11
    } trim_sel_e;

endpackage

// File: rtl/dac_trim_regbank.sv
// Per-channel register bank: holds sample, gain and offset trims.
// Assumes channel numbers at or above NUM_CH are never decoded.
// The gain LSB is stored as zero.
module dac_trim_regbank
    import dac_trim_pkg::*;
#(
    parameter int NUM_CH = 40,
    parameter int DW     = 12,
    parameter int AW     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [1:0]                 wr_sel,
    input  logic [DW-1:0]              wr_data,
    output logic [NUM_CH-1:0][DW-1:0]  sample_q,
    output logic [NUM_CH-1:0][DW-1:0]  gain_q,
    output logic [NUM_CH-1:0][DW-1:0]  offset_q
);
    localparam logic [DW-1:0] GAIN_UNITY  = {{(DW-1){1'b1}}, 1'b0};
    localparam logic [DW-1:0] OFFSET_ZERO = {1'b1, {(DW-1){1'b0}}};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic hit;

        // Decode a write aimed at this channel.
        always_comb hit = wr_en && (wr_addr == AW'(ch));

        // Hold this channel's three registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sample_q[ch] <= '0;
                gain_q[ch]   <= GAIN_UNITY;
                offset_q[ch] <= OFFSET_ZERO;
            end else if (hit) begin
                case (wr_sel)
                    SEL_SAMPLE: sample_q[ch] <= wr_data;
                    SEL_OFFSET: offset_q[ch] <= wr_data;
                    SEL_GAIN:   gain_q[ch]   <= {wr_data[DW-1:1], 1'b0};
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dac_trim_corrector.sv
// Combinational trim for one channel:
// out = ((gain + 2) * sample) >> DW, plus offset, minus half scale.
// The result is clamped to [0, 2**DW - 1]. Assumes unsigned inputs.
module dac_trim_corrector #(
    parameter int DW = 12
) (
    input  logic [DW-1:0] sample_i,
    input  logic [DW-1:0] gain_i,
    input  logic [DW-1:0] offset_i,
    output logic [DW-1:0] code_o
);
    localparam int PW = 2*DW + 1;
    localparam int SW = DW + 3;
    localparam logic [SW-1:0] HALF     = SW'(1) << (DW-1);
    localparam logic [SW-1:0] CODE_MAX = SW'((1 << DW) - 1);

    logic [DW:0]   gain_p2;
    logic [PW-1:0] product;
    logic [SW-1:0] sum;

    // Full-precision product, truncating scale and offset sum.
    always_comb begin
        gain_p2 = {1'b0, gain_i} + (DW+1)'(2);
        product = PW'(gain_p2) * PW'(sample_i);
        sum     = SW'(product >> DW) + SW'(offset_i) - HALF;
    end

    // Clamp the signed sum into the code range.
    always_comb begin
        if (sum[SW-1])            code_o = '0;
        else if (sum > CODE_MAX)  code_o = '1;
        else                      code_o = sum[DW-1:0];
    end
endmodule

// File: rtl/dac_trim_outreg.sv
// Second buffer stage: copies all pending codes to the outputs on load.
// Assumes load is a single-cycle strobe.
module dac_trim_outreg #(
    parameter int NUM_CH = 40,
    parameter int DW     = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [NUM_CH-1:0][DW-1:0] pend_i,
    output logic [NUM_CH-1:0][DW-1:0] code_q
);
    // Update every channel together when load is high.
    always_ff @(posedge clk) begin
        if (!rst_n)    code_q <= '0;
        else if (load) code_q <= pend_i;
    end
endmodule

// File: rtl/dac_trim_array.sv
// Top: register bank, per-channel trim and double-buffered outputs.
// Assumes inputs are synchronous to clk. Channel k's output occupies
// dac_code[DW*k +: DW].
module dac_trim_array #(
    parameter int NUM_CH = 40,
    parameter int DW     = 12,
    parameter int AW     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [1:0]           wr_sel,
    input  logic [DW-1:0]        wr_data,
    input  logic                 load,
    output logic [NUM_CH*DW-1:0] dac_code
);
    logic [NUM_CH-1:0][DW-1:0] sample_q;
    logic [NUM_CH-1:0][DW-1:0] gain_q;
    logic [NUM_CH-1:0][DW-1:0] offset_q;
    logic [NUM_CH-1:0][DW-1:0] pend;
    logic [NUM_CH-1:0][DW-1:0] code_q;

    dac_trim_regbank #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .sample_q (sample_q),
        .gain_q   (gain_q),
        .offset_q (offset_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_trim
        dac_trim_corrector #(.DW(DW)) corr_i (
            .sample_i (sample_q[ch]),
            .gain_i   (gain_q[ch]),
            .offset_i (offset_q[ch]),
            .code_o   (pend[ch])
        );
    end

    dac_trim_outreg #(.NUM_CH(NUM_CH), .DW(DW)) out_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .pend_i (pend),
        .code_q (code_q)
    );

    // Flatten the output registers onto the port.
    always_comb dac_code = code_q;
endmodule

// File: rtl/dac_trim_array_chk.sv
// Assertion checker for dac_trim_array, attached by bind.
// Assumes all write-port inputs are known after reset.
module dac_trim_array_chk #(
    parameter int NUM_CH = 40,
    parameter int DW     = 12,
    parameter int AW     = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [AW-1:0]             wr_addr,
    input logic [1:0]                wr_sel,
    input logic [DW-1:0]             wr_data,
    input logic                      load,
    input logic [NUM_CH*DW-1:0]      dac_code,
    input logic [NUM_CH-1:0][DW-1:0] sample_q,
    input logic [NUM_CH-1:0][DW-1:0] gain_q,
    input logic [NUM_CH-1:0][DW-1:0] offset_q,
    input logic [NUM_CH-1:0][DW-1:0] pend
);
    localparam logic [DW-1:0] LSB_CLR = ~DW'(1);

    // R7: outputs hold when no load is presented.
    a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dac_code));

    // R8: a load presents the trimmed codes from the cycle of the strobe.
    a_r8_load_takes_pending: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dac_code == $past(pend)));

    // R9: out-of-range channel numbers leave every register untouched.
    a_r9_high_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_addr} >= (AW+1)'(NUM_CH)))
        |=> ($stable(sample_q) && $stable(gain_q) && $stable(offset_q)));

    // R10: select 00 leaves every register untouched.
    a_r10_none_sel_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b00)
        |=> ($stable(sample_q) && $stable(gain_q) && $stable(offset_q)));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // R5: a gain write stores bits 11..1 with bit 0 cleared.
        a_r5_gain_lsb_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == 2'b01 && wr_addr == AW'(ch))
            |=> (gain_q[ch] == ($past(wr_data) & LSB_CLR)));

        // R4: reset restores unity gain and zero offset.
        a_r4_reset_defaults: assert property (@(posedge clk)
            !rst_n |=> (gain_q[ch] == {{(DW-1){1'b1}}, 1'b0}
                        && offset_q[ch] == {1'b1, {(DW-1){1'b0}}}
                        && sample_q[ch] == '0));
    end
endmodule

bind dac_trim_array dac_trim_array_chk #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .load     (load),
    .dac_code (dac_code),
    .sample_q (sample_q),
    .gain_q   (gain_q),
    .offset_q (offset_q),
    .pend     (pend)
);

// File: tb/dac_trim_array_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, buffering and ignored writes.
module dac_trim_array_tb_top;
    localparam int  NUM_CH = 40;
    localparam int  DW     = 12;
    localparam int  AW     = 6;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC   = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [AW-1:0]        wr_addr = '0;
    logic [1:0]           wr_sel = '0;
    logic [DW-1:0]        wr_data = '0;
    logic                 load = 1'b0;
    logic [NUM_CH*DW-1:0] dac_code;
    logic [NUM_CH*DW-1:0] snap;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Fields: channel, sample, gain, offset, expected code.
    localparam logic [53:0] VEC [NVEC] = '{
        {6'd0,  12'h123, 12'hFFE, 12'h800, 12'h123}, // R2 unity
        {6'd1,  12'h800, 12'h7FE, 12'h800, 12'h400}, // R6 gain 0.5
        {6'd2,  12'hFFF, 12'hBFE, 12'h800, 12'hBFF}, // R6 gain 0.75, truncation
        {6'd3,  12'h400, 12'hFFE, 12'h810, 12'h410}, // R6 offset +16
        {6'd4,  12'h010, 12'hFFE, 12'h7F0, 12'h000}, // R6 offset -16
        {6'd5,  12'h005, 12'hFFE, 12'h000, 12'h000}, // R3 clamp low
        {6'd6,  12'hF00, 12'hFFE, 12'hFFF, 12'hFFF}, // R3 clamp high
        {6'd39, 12'h3FF, 12'h3FE, 12'h900, 12'h1FF}, // R2 gain 0.25, last channel
        {6'd20, 12'hFFF, 12'h001, 12'h800, 12'h001}, // R5 gain LSB dropped
        {6'd7,  12'h7FF, 12'h000, 12'h800, 12'h000}  // R2 minimum gain
    };

    dac_trim_array #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .load     (load),
        .dac_code (dac_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] chan(input int ch);
        return dac_code[ch*DW +: DW];
    endfunction

    task automatic check(input string tag, input logic [NUM_CH*DW-1:0] act,
                         input logic [NUM_CH*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [1:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(ch); wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_load();
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: outputs are zero after reset.
        check("R4 reset outputs", dac_code, '0);

        // R4: default trims pass the sample through.
        wr(10, 2'b11, 12'hABC);
        do_load();
        check("R4 default passthrough", NUM_CH*DW'(chan(10)), NUM_CH*DW'(12'hABC));

        // R1 R2 R3 R5 R6: table of trims, one load per vector.
        for (int v = 0; v < NVEC; v++) begin
            wr(int'(VEC[v][53:48]), 2'b11, VEC[v][47:36]);
            wr(int'(VEC[v][53:48]), 2'b01, VEC[v][35:24]);
            wr(int'(VEC[v][53:48]), 2'b10, VEC[v][23:12]);
            do_load();
            check($sformatf("R2 vector %0d", v),
                  NUM_CH*DW'(chan(int'(VEC[v][53:48]))), NUM_CH*DW'(VEC[v][11:0]));
        end

        // R11: earlier channels kept their codes.
        check("R11 ch10 kept", NUM_CH*DW'(chan(10)), NUM_CH*DW'(12'hABC));
        check("R11 ch0 kept", NUM_CH*DW'(chan(0)), NUM_CH*DW'(12'h123));

        // R7: writes alone do not move outputs; one load updates both.
        wr(0, 2'b11, 12'h200);
        wr(1, 2'b11, 12'h400);
        repeat (3) @(negedge clk);
        check("R7 ch0 held", NUM_CH*DW'(chan(0)), NUM_CH*DW'(12'h123));
        check("R7 ch1 held", NUM_CH*DW'(chan(1)), NUM_CH*DW'(12'h400));
        do_load();
        check("R7 ch0 updated", NUM_CH*DW'(chan(0)), NUM_CH*DW'(12'h200));
        check("R7 ch1 updated", NUM_CH*DW'(chan(1)), NUM_CH*DW'(12'h200));

        // R8: write in the same cycle as load is not captured.
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd0; wr_sel = 2'b11; wr_data = 12'h300; load = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; load = 1'b0;
        check("R8 same-cycle write unseen", NUM_CH*DW'(chan(0)), NUM_CH*DW'(12'h200));
        do_load();
        check("R8 next load sees write", NUM_CH*DW'(chan(0)), NUM_CH*DW'(12'h300));

        // R9: channels 40 and 63 do not exist.
        snap = dac_code;
        wr(40, 2'b11, 12'hFFF);
        wr(63, 2'b10, 12'h000);
        wr(40, 2'b01, 12'h000);
        do_load();
        check("R9 high address ignored", dac_code, snap);

        // R10: select 00 changes nothing.
        wr(1, 2'b00, 12'hFFF);
        wr(0, 2'b00, 12'h000);
        do_load();
        check("R10 select 00 ignored", dac_code, snap);

        // R4: mid-run reset clears outputs and restores trims.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R4 reset clears outputs", dac_code, '0);
        wr(1, 2'b11, 12'h777);
        do_load();
        check("R4 trims restored", NUM_CH*DW'(chan(1)), NUM_CH*DW'(12'h777));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule